// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is the cycle control of a flow-through synchronous burst SRAM with a single shared data path. Two address strobes compete for the device, one driven by a processor and one by a cache controller. Three chip enables qualify them, and a set of write qualifiers chooses between reads and byte-granular writes. Every rising clock edge is classified as a deselect, a burst start, a burst continuation or a sleep cycle. From that class the block derives the per-lane write enables, the address-register load, the burst-counter advance and the bus drive enable. A small internal array stands in for the memory core, so the whole read and write path can be exercised at the ports.

A burst covers an aligned group of four words. Its low two address bits follow either an interleaved (XOR) order or a linear (modulo-four increment) order, chosen by a static input. Read data is flow-through: it is the array word at the address registered on the most recent edge, with no output register. The data path is modelled as a separate input bus, an output bus and a drive enable, in place of a bidirectional pad.

Top module: `sbsram_ctrl`

## Requirements
- R1: A burst starts only when, at the edge, `en1_n`=0, `en2`=1 and `en3_n`=0. A recognised strobe seen without all three enables is a deselect: it loads nothing, writes nothing and ends any burst, so `dq_oe` is 0 in the next cycle.
- R2: While `en1_n`=1, the processor strobe `pstb_n` is ignored. In that case the controller strobe or the burst continuation alone decides the cycle.
- R3: When `pstb_n` and `cstb_n` are both low (and `en1_n`=0), only the processor strobe is honoured.
- R4: A processor-strobe start is always a read (`byte_we`=0) whatever the write inputs are. On later continuation cycles of that burst the write inputs take effect.
- R5: A controller-strobe start (with the processor strobe not honoured) writes in its first cycle when the write inputs request a write. Otherwise it starts a read.
- R6: Lane decode: `wr_all_n`=0 requests all four lanes and overrides the byte inputs. Otherwise `wr_byte_n`=0 together with `lane_n[i]`=0 requests lane i, where lane i is data bits 8i+7..8i (lane 0 = bits 7:0, lane 3 = bits 31:24). A request for no lane is a read. `byte_we` shows the lanes written at the coming edge.
- R7: With both strobes inactive during a burst, `step_n`=0 advances the burst and `step_n`=1 repeats the current word. The advance follows one of two orders. With `burst_ilv`=1, position k is start XOR k. With `burst_ilv`=0, position k is (start + k) mod 4. In both orders the upper address bits stay fixed and the sequence wraps after four words.
- R8: After a read edge, `dq_out` equals the array word at the address registered on that edge, in the same cycle. `dq_oe` is 1 only while `drive_n`=0.
- R9: While the current inputs decode to a write cycle, `dq_oe` is 0 regardless of `drive_n`, even for a single-lane write.
- R10: `asleep` rises after the second rising edge that sees `sleep_req` high, and falls after the second edge that sees it low. While `asleep`=1 no write, load or advance occurs, and the array contents are kept.
- R11: A burst in progress when sleep begins is abandoned. After wake, `dq_oe` stays 0 and continuation cycles do nothing until a new start.
- R12: After reset, `dq_oe`=0 and `asleep`=0, and no burst is active: continuation inputs neither advance nor write.
- R13: `addr_load` is 1 exactly when the current inputs decode to a burst start. `cnt_adv` is 1 exactly when they decode to a continuation with `step_n`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req | input | 1 | Asynchronous low-power request, active high |
| burst_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| addr | input | ADDR_W | Word address captured on a start |
| pstb_n | input | 1 | Processor address strobe, active low |
| cstb_n | input | 1 | Controller address strobe, active low |
| en1_n | input | 1 | Chip enable 1, active low; also masks `pstb_n` |
| en2 | input | 1 | Chip enable 2, active high |
| en3_n | input | 1 | Chip enable 3, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_byte_n | input | 1 | Byte-write qualifier, active low |
| lane_n | input | DATA_W/8 | Per-lane write selects, active low |
| step_n | input | 1 | Burst advance, active low |
| drive_n | input | 1 | Asynchronous output enable, active low |
| din | input | DATA_W | Write data |
| dq_out | output | DATA_W | Flow-through read data |
| dq_oe | output | 1 | Drive enable for the shared data bus |
| byte_we | output | DATA_W/8 | Lanes written at the coming edge |
| addr_load | output | 1 | Address register loads at the coming edge |
| cnt_adv | output | 1 | Burst counter advances at the coming edge |
| asleep | output | 1 | Low-power state active |

## Verification
A wrong burst-counter state appears in `dq_out` in the same cycle as the faulty edge, because reads are flow-through. It is therefore caught on the next driven read, and the interleaved and linear walks from a non-zero start expose an XOR swapped for an add. A stale read or burst flag shows up as `dq_oe` high one cycle too long: after a write, after a deselect or after wake. A mis-timed sleep synchronizer shows up as `asleep` moving one edge early or late, or as a write landing in the array during sleep, which the next read of that word reveals.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  localparam int BURST_W = 2;
  localparam int LANE_W  = 8;

  typedef enum logic [2:0] {
    CY_IDLE,
    CY_DESEL,
    CY_SLEEP,
    CY_START_RD,
    CY_START_WR,
    CY_CONT_RD,
    CY_CONT_WR
  } cyc_e;

  // Position of the k-th word of a burst within its aligned group.
  function automatic logic [BURST_W-1:0] burst_pos(input logic [BURST_W-1:0] base,
                                                   input logic [BURST_W-1:0] count,
                                                   input logic interleave);
    if (interleave) return base ^ count;
    return BURST_W'(base + count);
  endfunction

  function automatic logic cyc_is_start(input cyc_e c);
    return (c == CY_START_RD) || (c == CY_START_WR);
  endfunction

  function automatic logic cyc_is_cont(input cyc_e c);
    return (c == CY_CONT_RD) || (c == CY_CONT_WR);
  endfunction

  function automatic logic cyc_is_write(input cyc_e c);
    return (c == CY_START_WR) || (c == CY_CONT_WR);
  endfunction

  function automatic logic cyc_is_read(input cyc_e c);
    return (c == CY_START_RD) || (c == CY_CONT_RD);
  endfunction
endpackage

// File: rtl/sbsram_sleep.sv
module sbsram_sleep #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  output logic asleep
);
  // The last synchronizer stage doubles as the sleep state register:
  // entry and exit both take SYNC_STAGES edges.
  logic [SYNC_STAGES-1:0] sync_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sleep_req;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], sleep_req};
      end
    end
  endgenerate

  assign asleep = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/sbsram_decode.sv
module sbsram_decode
  import sbsram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             asleep,
  input  logic             burst_on,
  input  logic             pstb_n,
  input  logic             cstb_n,
  input  logic             en1_n,
  input  logic             en2,
  input  logic             en3_n,
  input  logic             wr_all_n,
  input  logic             wr_byte_n,
  input  logic [LANES-1:0] lane_n,
  input  logic             step_n,
  output cyc_e             cyc,
  output logic [LANES-1:0] lane_we,
  output logic             addr_load,
  output logic             cnt_adv,
  output logic             wr_cycle,
  output logic             rd_cycle
);
  logic             sel_all;
  logic             p_seen;
  logic             c_seen;
  logic             wr_ask;
  logic [LANES-1:0] want;

  assign sel_all = !en1_n && en2 && !en3_n;
  assign p_seen  = !pstb_n && !en1_n;   // processor strobe masked by enable 1
  assign c_seen  = !cstb_n;

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign want[i] = !wr_all_n || (!wr_byte_n && !lane_n[i]);
    end
  endgenerate

  assign wr_ask = |want;

  always_comb begin
    cyc = CY_IDLE;
    if (asleep)        cyc = CY_SLEEP;
    else if (p_seen)   cyc = sel_all ? CY_START_RD : CY_DESEL;
    else if (c_seen)   cyc = !sel_all ? CY_DESEL : (wr_ask ? CY_START_WR : CY_START_RD);
    else if (burst_on) cyc = wr_ask ? CY_CONT_WR : CY_CONT_RD;
  end

  assign wr_cycle  = cyc_is_write(cyc);
  assign rd_cycle  = cyc_is_read(cyc);
  assign lane_we   = wr_cycle ? want : '0;
  assign addr_load = cyc_is_start(cyc);
  assign cnt_adv   = cyc_is_cont(cyc) && !step_n;
endmodule

// File: rtl/sbsram_burst.sv
module sbsram_burst
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] acc_addr
);
  localparam int HI_W = ADDR_W - BURST_W;

  logic [HI_W-1:0]    hi_q;
  logic [BURST_W-1:0] base_q;
  logic [BURST_W-1:0] count_q;
  logic [BURST_W-1:0] count_nxt;

  assign count_nxt = count_q + BURST_W'(1);
  assign cur_addr  = {hi_q, burst_pos(base_q, count_q, interleave)};

  // Address of the access performed at the coming edge.
  always_comb begin
    if (load)     acc_addr = ext_addr;
    else if (adv) acc_addr = {hi_q, burst_pos(base_q, count_nxt, interleave)};
    else          acc_addr = cur_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      base_q  <= '0;
      count_q <= '0;
    end else if (load) begin
      hi_q    <= ext_addr[ADDR_W-1:BURST_W];
      base_q  <= ext_addr[BURST_W-1:0];
      count_q <= '0;
    end else if (adv) begin
      count_q <= count_nxt;
    end
  end
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic                      clk,
  input  logic [LANES-1:0]          we,
  input  logic [ADDR_W-1:0]         waddr,
  input  logic [LANES*LANE_W-1:0]   wdata,
  input  logic [ADDR_W-1:0]         raddr,
  output logic [LANES*LANE_W-1:0]   rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
        if (we[i]) mem[waddr] <= wdata[i*LANE_W +: LANE_W];
      end
      assign rdata[i*LANE_W +: LANE_W] = mem[raddr];
    end
  endgenerate
endmodule

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
  import sbsram_pkg::*;
#(
  parameter  int ADDR_W      = 8,
  parameter  int DATA_W      = 32,
  parameter  int SYNC_STAGES = 2,
  localparam int LANES       = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req,
  input  logic              burst_ilv,
  input  logic [ADDR_W-1:0] addr,
  input  logic              pstb_n,
  input  logic              cstb_n,
  input  logic              en1_n,
  input  logic              en2,
  input  logic              en3_n,
  input  logic              wr_all_n,
  input  logic              wr_byte_n,
  input  logic [LANES-1:0]  lane_n,
  input  logic              step_n,
  input  logic              drive_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic [LANES-1:0]  byte_we,
  output logic              addr_load,
  output logic              cnt_adv,
  output logic              asleep
);
  cyc_e              cyc;
  logic              burst_q;
  logic              rd_q;
  logic              wr_cycle;
  logic              rd_cycle;
  logic [ADDR_W-1:0] cur_addr;
  logic [ADDR_W-1:0] acc_addr;

  sbsram_sleep #(.SYNC_STAGES(SYNC_STAGES)) u_sleep (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_req (sleep_req),
    .asleep    (asleep)
  );

  sbsram_decode #(.LANES(LANES)) u_decode (
    .asleep    (asleep),
    .burst_on  (burst_q),
    .pstb_n    (pstb_n),
    .cstb_n    (cstb_n),
    .en1_n     (en1_n),
    .en2       (en2),
    .en3_n     (en3_n),
    .wr_all_n  (wr_all_n),
    .wr_byte_n (wr_byte_n),
    .lane_n    (lane_n),
    .step_n    (step_n),
    .cyc       (cyc),
    .lane_we   (byte_we),
    .addr_load (addr_load),
    .cnt_adv   (cnt_adv),
    .wr_cycle  (wr_cycle),
    .rd_cycle  (rd_cycle)
  );

  sbsram_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (addr_load),
    .adv        (cnt_adv),
    .interleave (burst_ilv),
    .ext_addr   (addr),
    .cur_addr   (cur_addr),
    .acc_addr   (acc_addr)
  );

  sbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_array (
    .clk   (clk),
    .we    (byte_we),
    .waddr (acc_addr),
    .wdata (din),
    .raddr (cur_addr),
    .rdata (dq_out)
  );

  // Burst stays open across starts and continuations; any other cycle ends it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_q <= 1'b0;
      rd_q    <= 1'b0;
    end else begin
      burst_q <= cyc_is_start(cyc) || cyc_is_cont(cyc);
      rd_q    <= rd_cycle;
    end
  end

  assign dq_oe = !drive_n && rd_q && !wr_cycle && !asleep;
endmodule

// File: rtl/sbsram_ctrl_chk.sv
module sbsram_ctrl_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sleep_req,
  input logic             pstb_n,
  input logic             en1_n,
  input logic             en2,
  input logic             en3_n,
  input logic             drive_n,
  input logic [LANES-1:0] byte_we,
  input logic             dq_oe,
  input logic             addr_load,
  input logic             cnt_adv,
  input logic             asleep
);
  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    addr_load |-> (!en1_n && en2 && !en3_n)); // R1

  AST_PSTB_START_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (!pstb_n && !en1_n) |-> (byte_we == '0)); // R4

  AST_DRIVE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    drive_n |-> !dq_oe); // R8

  AST_WRITE_RELEASES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_we != '0) |-> !dq_oe); // R9

  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> (byte_we == '0 && !addr_load && !cnt_adv)); // R10

  AST_SLEEP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(sleep_req, 2)); // R10

  AST_WAKE_HIGHZ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |-> !dq_oe); // R11
endmodule

bind sbsram_ctrl sbsram_ctrl_chk #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sleep_req (sleep_req),
  .pstb_n    (pstb_n),
  .en1_n     (en1_n),
  .en2       (en2),
  .en3_n     (en3_n),
  .drive_n   (drive_n),
  .byte_we   (byte_we),
  .dq_oe     (dq_oe),
  .addr_load (addr_load),
  .cnt_adv   (cnt_adv),
  .asleep    (asleep)
);

// File: tb/sbsram_ctrl_bench.sv
module sbsram_ctrl_bench;
  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sleep_req;
  logic          burst_ilv;
  logic [AW-1:0] addr;
  logic          pstb_n, cstb_n, en1_n, en2, en3_n;
  logic          wr_all_n, wr_byte_n;
  logic [3:0]    lane_n;
  logic          step_n, drive_n;
  logic [DW-1:0] din;
  logic [DW-1:0] dq_out;
  logic          dq_oe;
  logic [3:0]    byte_we;
  logic          addr_load, cnt_adv, asleep;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference state
  logic [DW-1:0] m_mem [1<<AW];
  logic [AW-3:0] m_hi;
  logic [1:0]    m_base, m_step;
  logic          m_act, m_rd, m_s0, m_s1;

  always #5 clk = ~clk;

  sbsram_ctrl u_sbsram_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .burst_ilv(burst_ilv),
    .addr(addr), .pstb_n(pstb_n), .cstb_n(cstb_n), .en1_n(en1_n), .en2(en2),
    .en3_n(en3_n), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_n(lane_n),
    .step_n(step_n), .drive_n(drive_n), .din(din), .dq_out(dq_out),
    .dq_oe(dq_oe), .byte_we(byte_we), .addr_load(addr_load),
    .cnt_adv(cnt_adv), .asleep(asleep)
  );

  function automatic logic [1:0] f_pos(input logic [1:0] b, input logic [1:0] k, input logic ilv);
    logic [2:0] s;
    if (ilv) return {b[1] ^ k[1], b[0] ^ k[0]};
    s = {1'b0, b} + {1'b0, k};
    return s[1:0];
  endfunction

  function automatic logic [3:0] f_lanes(input logic all_n, input logic byt_n, input logic [3:0] sel_n);
    if (!all_n) return 4'b1111;
    if (byt_n)  return 4'b0000;
    return ~sel_n;
  endfunction

  function automatic logic [DW-1:0] pre(input logic [AW-1:0] a);
    return {a, a, a, a} ^ 32'hA500_0000;
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle_in();
    pstb_n = 1; cstb_n = 1; en1_n = 0; en2 = 1; en3_n = 0;
    wr_all_n = 1; wr_byte_n = 1; lane_n = 4'hF; step_n = 1; drive_n = 0;
    addr = '0; din = '0;
  endtask

  // Check combinational outputs against the model, then advance one edge.
  task automatic tick();
    logic [AW-1:0] cur, wa;
    logic [3:0]    ln, ewe;
    logic          slp, all, st, ps, des, cn, wr, eoe;
    #1;
    slp = m_s1;
    cur = {m_hi, f_pos(m_base, m_step, burst_ilv)};
    ln  = f_lanes(wr_all_n, wr_byte_n, lane_n);
    all = (en1_n == 1'b0) && (en2 == 1'b1) && (en3_n == 1'b0);
    st = 0; ps = 0; des = 0; cn = 0; wa = cur;
    if (!slp) begin
      if (pstb_n == 1'b0 && en1_n == 1'b0) begin
        if (all) begin st = 1; ps = 1; end else des = 1;
      end else if (cstb_n == 1'b0) begin
        if (all) st = 1; else des = 1;
      end else if (m_act) cn = 1;
    end
    wr  = (ln != 4'b0) && ((st && !ps) || cn);
    ewe = wr ? ln : 4'b0;
    eoe = !drive_n && m_rd && !wr && !slp;
    chk("R6 byte_we", 32'(byte_we), 32'(ewe));
    chk("R13 addr_load", 32'(addr_load), 32'(st));
    chk("R13 cnt_adv", 32'(cnt_adv), 32'(cn && !step_n));
    chk("R8 dq_oe", 32'(dq_oe), 32'(eoe));
    chk("R10 asleep", 32'(asleep), 32'(slp));
    if (eoe) chk("R8 dq_out", dq_out, m_mem[cur]);
    if (slp) begin
      m_act = 0; m_rd = 0;
    end else if (st) begin
      m_hi = addr[AW-1:2]; m_base = addr[1:0]; m_step = 0;
      m_act = 1; m_rd = !wr; wa = addr;
    end else if (des) begin
      m_act = 0; m_rd = 0;
    end else if (cn) begin
      if (!step_n) m_step = m_step + 2'd1;
      m_rd = !wr;
      wa = {m_hi, f_pos(m_base, m_step, burst_ilv)};
    end else begin
      m_rd = 0;
    end
    if (wr) begin
      for (int i = 0; i < 4; i++)
        if (ln[i]) m_mem[wa][8*i +: 8] = din[8*i +: 8];
    end
    m_s1 = m_s0;
    m_s0 = sleep_req;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] seq_i [4];
    logic [AW-1:0] seq_l [4];
    int unsigned   sd;
    seq_i = '{8'h46, 8'h47, 8'h44, 8'h45};
    seq_l = '{8'h4E, 8'h4F, 8'h4C, 8'h4D};
    sd = $urandom(32'h5EED_0042);
    rst_n = 0; sleep_req = 0; burst_ilv = 1;
    idle_in();
    m_act = 0; m_rd = 0; m_s0 = 0; m_s1 = 0; m_hi = '0; m_base = '0; m_step = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk("R12 dq_oe after reset", 32'(dq_oe), 0);
    chk("R12 asleep after reset", 32'(asleep), 0);
    step_n = 0; wr_all_n = 0;
    #1;
    chk("R12 no advance without burst", 32'(cnt_adv), 0);
    chk("R12 no write without burst", 32'(byte_we), 0);
    tick();

    // preload every word through controller-strobe write starts
    for (int a = 0; a < (1 << AW); a++) begin
      idle_in(); cstb_n = 0; wr_all_n = 0; addr = AW'(a); din = pre(AW'(a));
      tick();
    end

    // R3/R4: both strobes with write inputs -> processor read start
    idle_in(); pstb_n = 0; cstb_n = 0; wr_all_n = 0; addr = 8'h20;
    #1;
    chk("R3 both strobes no write", 32'(byte_we), 0);
    chk("R3 both strobes load", 32'(addr_load), 1);
    tick();
    idle_in(); wr_all_n = 0; din = 32'hDEAD_BEEF;
    #1;
    chk("R4 write on continuation", 32'(byte_we), 32'hF);
    chk("R9 bus released on write", 32'(dq_oe), 0);
    tick();
    idle_in();
    tick();
    chk("R4 continuation data", dq_out, 32'hDEAD_BEEF);
    drive_n = 1;
    #1;
    chk("R8 drive disabled", 32'(dq_oe), 0);

    // R2: processor strobe masked by enable 1, burst continues
    idle_in(); en1_n = 1; pstb_n = 0;
    #1;
    chk("R2 masked strobe no load", 32'(addr_load), 0);
    chk("R2 continuation still drives", 32'(dq_oe), 1);
    tick();

    // R1: controller strobe with enable 2 inactive deselects
    idle_in(); en2 = 0; cstb_n = 0; wr_all_n = 0; addr = 8'h33;
    #1;
    chk("R1 deselect no write", 32'(byte_we), 0);
    chk("R1 deselect no load", 32'(addr_load), 0);
    tick();
    idle_in(); step_n = 0;
    #1;
    chk("R1 bus idle after deselect", 32'(dq_oe), 0);
    chk("R1 burst ended", 32'(cnt_adv), 0);
    tick();

    // R5/R6: partial write on a controller start, then read it back
    idle_in(); cstb_n = 0; wr_byte_n = 0; lane_n = 4'b1010; addr = 8'h30; din = 32'h1122_3344;
    #1;
    chk("R6 lanes 0 and 2", 32'(byte_we), 32'h5);
    chk("R9 released on partial write", 32'(dq_oe), 0);
    tick();
    idle_in(); cstb_n = 0; addr = 8'h30;
    #1;
    chk("R5 controller read start", 32'(byte_we), 0);
    tick();
    idle_in();
    #1;
    chk("R5 read drives", 32'(dq_oe), 1);
    chk("R6 merged lanes", dq_out, 32'h9522_3044);
    tick();

    // R7: interleaved walk from start position 2
    burst_ilv = 1;
    idle_in(); pstb_n = 0; addr = 8'h46;
    tick();
    for (int k = 0; k < 4; k++) begin
      idle_in(); step_n = 0;
      #1;
      chk("R7 interleaved order", dq_out, pre(seq_i[k]));
      chk("R13 advance flag", 32'(cnt_adv), 1);
      tick();
    end
    chk("R7 interleaved wrap", dq_out, pre(8'h46));

    // R7: linear walk from start position 2, then suspend
    burst_ilv = 0;
    idle_in(); pstb_n = 0; addr = 8'h4E;
    tick();
    for (int k = 0; k < 4; k++) begin
      idle_in(); step_n = 0;
      #1;
      chk("R7 linear order", dq_out, pre(seq_l[k]));
      tick();
    end
    idle_in();
    #1;
    chk("R7 linear wrap", dq_out, pre(8'h4E));
    tick();
    chk("R7 suspend holds", dq_out, pre(8'h4E));

    // R10/R11: sleep entry, ignored write, exit
    idle_in(); sleep_req = 1;
    tick();
    chk("R10 not yet asleep", 32'(asleep), 0);
    tick();
    chk("R10 asleep after two edges", 32'(asleep), 1);
    idle_in(); cstb_n = 0; wr_all_n = 0; addr = 8'h50; din = 32'hFFFF_FFFF;
    #1;
    chk("R10 write ignored", 32'(byte_we), 0);
    chk("R10 load ignored", 32'(addr_load), 0);
    tick();
    tick();
    idle_in(); sleep_req = 0;
    tick();
    chk("R10 still asleep", 32'(asleep), 1);
    tick();
    chk("R10 awake after two edges", 32'(asleep), 0);
    step_n = 0;
    #1;
    chk("R11 bus idle after wake", 32'(dq_oe), 0);
    chk("R11 burst abandoned", 32'(cnt_adv), 0);
    tick();
    idle_in(); pstb_n = 0; addr = 8'h50;
    tick();
    idle_in();
    #1;
    chk("R10 contents kept", dq_out, pre(8'h50));
    tick();

    // constrained random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      pstb_n    = ($urandom % 100) >= 15;
      cstb_n    = ($urandom % 100) >= 20;
      en1_n     = ($urandom % 100) >= 85;
      en2       = ($urandom % 100) < 90;
      en3_n     = ($urandom % 100) >= 90;
      wr_all_n  = ($urandom % 100) >= 10;
      wr_byte_n = ($urandom % 100) >= 40;
      lane_n    = 4'($urandom);
      step_n    = ($urandom % 2) == 0;
      drive_n   = ($urandom % 100) >= 80;
      addr      = AW'($urandom);
      din       = $urandom;
      if (($urandom % 100) < 2) sleep_req = ~sleep_req;
      if ((n % 500) == 0) burst_ilv = 1'($urandom);
      tick();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule